// File: doc/BRIEF.md
# General-Purpose I/O Port with Pin and Latch Read Paths

This block is a parameterized-width (8 bits by default) general-purpose I/O port that sits on a small microcontroller register bus. It keeps an output latch and a per-bit direction register. It also samples the external pin levels through a two-stage synchronizer. The pads are modelled as three separate vectors: pin input, pin output value and pin output enable. No bidirectional nets are needed.

Two bus addresses write the same output latch. Their reads differ. The pin address returns the synchronized pin levels. The latch address returns the stored latch value. Software that does a bit-set as read, modify and write back on the pin address can therefore corrupt a latch bit. This happens when an output pin is held at the opposite level from outside. The same operation on the latch address keeps the bit. A third address holds the direction register. The fourth address is reserved.

Top module: `gpio_dual_port`

## Requirements
- R1: A write with `bus_wr` high and `bus_addr` = 0 (pin address) loads `bus_wdata` into the output latch at the clock edge.
- R2: A write with `bus_wr` high and `bus_addr` = 1 (latch address) loads `bus_wdata` into the same output latch at the clock edge.
- R3: With `bus_addr` = 0, `bus_rdata` combinationally shows `pin_in` as it was sampled two rising clock edges earlier, through two register stages.
- R4: With `bus_addr` = 1, `bus_rdata` combinationally shows the output latch, whatever the level on `pin_in`.
- R5: Bit i of `pin_oe` is 1 exactly when direction bit i is 1. Direction bit 0 means input, with the driver off. `pin_out` always equals the output latch.
- R6: While `rst_n` is low, the latch, the direction register and both synchronizer stages are cleared. So `pin_oe`, `pin_out` and `bus_rdata` are all 0.
- R7: A write with `bus_addr` = 2 loads the direction register, which reads back at address 2. Writes to address 3 change nothing, and address 3 reads as 0.
- R8: A read of address 0, OR with a mask, and write back to address 0 clears any latch bit whose output pin is held low from outside. The same sequence on address 1 keeps every latch bit and sets the mask bits.
- R9: With `bus_wr` low, no register changes. Reads have no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 pin, 1 latch, 2 direction, 3 reserved |
| bus_wr | input | 1 | Write strobe, single cycle |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Combinational read data for `bus_addr` |
| pin_in | input | WIDTH | Levels seen on the pads |
| pin_out | output | WIDTH | Value driven onto the pads |
| pin_oe | output | WIDTH | Per-pin driver enable, 1 = drive |

## Verification
The hardest case to reach is the read-modify-write corruption. It needs four things at once: a pin set as output, a latch bit at 1, the outside level on that pin forced to 0, and enough cycles for the forced level to pass the synchronizer before the read. The bench plays the part of both the pad and the software. It sets the direction to all outputs and writes the latch. It then drives `pin_in` with one bit pulled low and waits two edges. Next it reads address 0 and writes back the value ORed with a mask, then reads the latch. It repeats the same sequence on address 1 to show the bit survives. Random bus traffic and pin changes run beside this and are compared every cycle against a behavioural model.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    // Register select codes on the 2-bit bus address
    typedef enum logic [1:0] {
        SEL_PIN   = 2'd0,
        SEL_LATCH = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_RSVD  = 2'd3
    } reg_sel_e;

    localparam int unsigned ADDR_W = 2;
    localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for the pad input levels
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = gpio_pkg::SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stage[0] = async_in;
        for (int k = 1; k < int'(STAGES); k++) begin
            s_d.stage[k] = s_q.stage[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.stage[LAST];

    // warm-up counter so the delay check only looks back over cycles since reset
    logic [1:0] warm_d, warm_q;
    always_comb warm_d = (warm_q == 2'd2) ? warm_q : warm_q + 2'd1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= '0;
        else        warm_q <= warm_d;
    end

    generate
        if (STAGES == 2) begin : g_chk2
            // R3
            sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q == 2'd2) |-> (sync_out == $past(async_in, 2)));
        end
    endgenerate
endmodule

// File: rtl/gpio_regs.sv
// Output latch and direction register with the bus write decode
module gpio_regs #(
    parameter int unsigned WIDTH = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [gpio_pkg::ADDR_W-1:0]     wr_addr,
    input  logic                            wr_en,
    input  logic [WIDTH-1:0]                wr_data,
    output logic [WIDTH-1:0]                latch_val,
    output logic [WIDTH-1:0]                dir_val
);
    import gpio_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] latch;
        logic [WIDTH-1:0] dir;
    } regs_t;

    regs_t r_d, r_q;
    reg_sel_e sel;

    always_comb begin
        sel = reg_sel_e'(wr_addr);
        r_d = r_q;
        if (wr_en) begin
            unique case (sel)
                SEL_PIN,
                SEL_LATCH: r_d.latch = wr_data;
                SEL_DIR:   r_d.dir   = wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign latch_val = r_q.latch;
    assign dir_val   = r_q.dir;

    // R1 R2
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == 2'd0 || wr_addr == 2'd1)) |=> (latch_val == $past(wr_data)));

    // R7
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2) |=> (dir_val == $past(wr_data) && $stable(latch_val)));

    // R7
    rsvd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3) |=> ($stable(latch_val) && $stable(dir_val)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> ($stable(latch_val) && $stable(dir_val)));
endmodule

// File: rtl/gpio_rdmux.sv
// Combinational read-data select
module gpio_rdmux #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [gpio_pkg::ADDR_W-1:0] rd_addr,
    input  logic [WIDTH-1:0]            pin_sync,
    input  logic [WIDTH-1:0]            latch_val,
    input  logic [WIDTH-1:0]            dir_val,
    output logic [WIDTH-1:0]            rd_data
);
    import gpio_pkg::*;

    always_comb begin
        unique case (reg_sel_e'(rd_addr))
            SEL_PIN:   rd_data = pin_sync;
            SEL_LATCH: rd_data = latch_val;
            SEL_DIR:   rd_data = dir_val;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gpio_dual_port.sv
// Top: GPIO port with two write aliases and split pin/latch reads
module gpio_dual_port #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] latch_val;
    logic [WIDTH-1:0] dir_val;

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_addr   (bus_addr),
        .wr_en     (bus_wr),
        .wr_data   (bus_wdata),
        .latch_val (latch_val),
        .dir_val   (dir_val)
    );

    gpio_rdmux #(.WIDTH(WIDTH)) u_mux (
        .rd_addr   (bus_addr),
        .pin_sync  (pin_sync),
        .latch_val (latch_val),
        .dir_val   (dir_val),
        .rd_data   (bus_rdata)
    );

    // Direction 1 = output; 0 = input with driver off
    assign pin_oe  = dir_val;
    assign pin_out = latch_val;

    // R4
    latch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd1) |-> (bus_rdata == pin_out));

    // R7
    rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |-> (bus_rdata == '0));

    // R5
    dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd2) |-> (bus_rdata == pin_oe));
endmodule

// File: tb/sim_gpio_dual_port.sv
module sim_gpio_dual_port;
    localparam int W = 8;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out;
    logic [W-1:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference
    int m_lat = 0, m_dir = 0;
    int m_pins[$];   // recent samples of pin_in, oldest first

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_dual_port #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_rd(int a);
        case (a)
            0: return m_pins[0];
            1: return m_lat;
            2: return m_dir;
            default: return 0;
        endcase
    endfunction

    // one bus cycle: drive after negedge, compare, then advance model at posedge
    task automatic step(int a, bit wr, int wd, int pins, output int rd);
        @(negedge clk);
        bus_addr = 2'(a); bus_wr = wr; bus_wdata = W'(wd); pin_in = W'(pins);
        #1;
        rd = int'(bus_rdata);
        check("R3/R4/R7 model rdata", rd, model_rd(a));
        check("R1/R2 model pin_out", int'(pin_out), m_lat);
        check("R5 model pin_oe", int'(pin_oe), m_dir);
        @(posedge clk);
        if (wr) begin
            if (a == 0 || a == 1) m_lat = wd;
            else if (a == 2)      m_dir = wd;
        end
        void'(m_pins.pop_front());
        m_pins.push_back(pins);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int rd;
        int pins;
        m_pins.push_back(0); m_pins.push_back(0);
        pin_in = 8'hA5;
        repeat (3) @(negedge clk);
        // R6 reset state
        check("R6 latch in reset", int'(pin_out), 0);
        check("R6 oe in reset", int'(pin_oe), 0);
        bus_addr = 2'd0; #1;
        check("R6 pin read in reset", int'(bus_rdata), 0);
        pin_in = '0;
        @(negedge clk); rst_n = 1'b1;

        // R1 write via pin address, read via latch
        step(0, 1, 8'h3C, 0, rd);
        step(1, 0, 0, 0, rd);
        check("R1 latch after pin-address write", rd, 8'h3C);
        // R2 write via latch address
        step(1, 1, 8'hC3, 0, rd);
        step(1, 0, 0, 8'hFF, rd);
        check("R2 latch after latch-address write", rd, 8'hC3);
        // R4 latch read ignores pins
        step(1, 0, 0, 8'h00, rd);
        check("R4 latch read with pins changing", rd, 8'hC3);
        // R5 direction default: no drive
        check("R5 oe with direction 0", int'(pin_oe), 0);
        step(2, 1, 8'h0F, 0, rd);
        step(2, 0, 0, 0, rd);
        check("R7 direction readback", rd, 8'h0F);
        check("R5 oe follows direction", int'(pin_oe), 8'h0F);
        check("R5 pin_out equals latch", int'(pin_out), 8'hC3);
        // R3 two-edge latency
        step(0, 0, 0, 8'h5A, rd);
        step(0, 0, 0, 8'h5A, rd);
        check("R3 pin read after one edge", rd, 0);
        step(0, 0, 0, 8'h5A, rd);
        check("R3 pin read after two edges", rd, 8'h5A);
        // R7 reserved address
        step(3, 1, 8'hFF, 8'h5A, rd);
        check("R7 reserved reads zero", rd, 0);
        step(1, 0, 0, 8'h5A, rd);
        check("R7 reserved write left latch", rd, 8'hC3);
        step(2, 0, 0, 8'h5A, rd);
        check("R7 reserved write left direction", rd, 8'h0F);
        // R9 no write without strobe
        step(1, 0, 8'h11, 8'h5A, rd);
        step(2, 0, 8'h22, 8'h5A, rd);
        step(1, 0, 0, 8'h5A, rd);
        check("R9 latch unchanged without strobe", rd, 8'hC3);

        // R8 read-modify-write hazard
        step(2, 1, 8'hFF, 0, rd);
        step(1, 1, 8'h0F, 0, rd);
        pins = 8'h0E;                  // bit0 held low from outside
        step(1, 0, 0, pins, rd);
        step(1, 0, 0, pins, rd);
        step(0, 0, 0, pins, rd);       // software reads pin address
        check("R8 pin read sees held-low bit", rd, 8'h0E);
        step(0, 1, rd | 8'h80, pins, rd);
        step(1, 0, 0, pins, rd);
        check("R8 pin-address bit-set corrupts latch", rd, 8'h8E);
        step(1, 1, 8'h0F, pins, rd);
        step(1, 0, 0, pins, rd);       // software reads latch address
        step(1, 1, rd | 8'h80, pins, rd);
        step(1, 0, 0, pins, rd);
        check("R8 latch-address bit-set preserves latch", rd, 8'h8F);

        // random traffic compared against the model each cycle
        for (int i = 0; i < 400; i++) begin
            step(int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
                 int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), rd);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule